// File: doc/BRIEF.md
# Statically Scheduled Crossbar Node

This block is one communication node of a mesh. On every clock it reads one instruction from a local instruction memory. The instruction names a source for each of six crossbar outputs. Four of those outputs are the mesh neighbours (north, east, south, west) and one is the local core. The sixth output feeds a zero-test comparator that lives inside the node. Words move with a one-bit validity tag. Because the routing schedule is written ahead of time by a compiler, no arbitration takes place at run time.

A program counter walks through the instruction memory. It advances by one on each cycle unless the instruction forces a jump, or unless the instruction enables the comparator and the compared word is not a valid zero. In either of those cases it loads the instruction's branch target. A loop therefore repeats a fixed transfer pattern until the core presents a zero count. This gives DMA-style block transfers with no controller outside the node. The memory is loaded through a plain write port, normally while the node is held in reset.

Top module: `sxn_node`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 0 and every data output is 0 with its tag low; this takes effect immediately, without waiting for a clock edge.
- R2: The instruction memory holds 256 words of 32 bits. A word is stored at `cfg_addr_i` on a rising edge where `cfg_we_i` is high, and this also works during reset. The word at `pc_o` is the instruction in force. Its layout is: bits [17:0] hold six 3-bit source selects, with output n at bits [3n+2:3n] (n = 0 north, 1 east, 2 south, 3 west, 4 core, 5 comparator); bits [25:18] hold the branch target; bit 26 enables the compare; bit 27 forces a jump; bits [31:28] are ignored.
- R3: Source codes 0, 1, 2, 3 and 4 pick the north, east, south, west and core inputs respectively. The selected word and its tag appear on the output one clock after the edge at which the instruction was in force. One source may feed several outputs at once.
- R4: Source codes 5, 6 and 7 drive the output with data 0 and the tag low.
- R5: The tag is carried together with the data. An input whose tag is low is routed with its data unchanged and its tag still low.
- R6: With neither the compare nor the jump bit set, the program counter advances by one. It wraps from 255 to 0.
- R7: With the jump bit set, the program counter loads the branch target, whatever the compare result.
- R8: With compare enabled and the jump bit clear, the comparator input is tested in the same cycle. A valid word equal to zero advances the program counter by one. A valid nonzero word loads the branch target.
- R9: With compare enabled and the jump bit clear, a comparator input whose tag is low counts as nonzero, so the program counter loads the branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Instruction memory write enable |
| cfg_addr_i | input | 8 | Instruction memory write address |
| cfg_data_i | input | 32 | Instruction word to write |
| nbr_data_i | input | 4*DW | Neighbour input data; index 0 north, 1 east, 2 south, 3 west |
| nbr_vld_i | input | 4 | Neighbour input tags |
| core_data_i | input | DW | Local core FIFO data |
| core_vld_i | input | 1 | Local core FIFO tag |
| nbr_data_o | output | 4*DW | Registered neighbour output data; same indexing as the inputs |
| nbr_vld_o | output | 4 | Registered neighbour output tags |
| core_data_o | output | DW | Registered data to the local core |
| core_vld_o | output | 1 | Registered tag to the local core |
| pc_o | output | 8 | Program counter, the address of the instruction in force |

## Verification
The routing tests use a rotation of the neighbour ports, all-dead codes, a broadcast from a single source and an untagged word. These separate a correct decode of the select fields from swapped fields, from stuck selects and from a tag that is dropped or forced high. The sequencer tests drive the comparator with a valid zero, a valid nonzero value and an untagged zero. They also drive a jump combined with a zero that would otherwise advance, and a compare on a neighbour input while the core carries a nonzero value. Together these pin down the branch polarity, the tag rule, the jump priority and which crossbar output the comparator reads. A countdown loop checks that data transfers and branching work together, and a jump to 254 checks the wrap to 0.

// File: rtl/sxn_pkg.sv
package sxn_pkg;
  localparam int unsigned SXN_IW     = 32;
  localparam int unsigned SXN_AW     = 8;
  localparam int unsigned SXN_DEPTH  = 1 << SXN_AW;
  localparam int unsigned SXN_SELW   = 3;
  localparam int unsigned SXN_NOUT   = 6;
  localparam int unsigned SXN_NSRC   = 5;
  localparam int unsigned SXN_NNBR   = 4;
  localparam int unsigned SXN_NREG   = SXN_NOUT - 1;
  localparam int unsigned SXN_SPAREW = SXN_IW - 2 - SXN_AW - SXN_SELW * SXN_NOUT;

  // output / source indices
  localparam int unsigned SXN_CORE = 4;
  localparam int unsigned SXN_CMP  = 5;

  typedef logic [SXN_SELW-1:0] sel_t;
  typedef logic [SXN_AW-1:0]   addr_t;

  typedef struct packed {
    logic [SXN_SPAREW-1:0]  spare;
    logic                   fjump;
    logic                   cmp_en;
    addr_t                  target;
    sel_t [SXN_NOUT-1:0]    sel;
  } instr_t;
endpackage

// File: rtl/sxn_imem.sv
module sxn_imem #(
  parameter int unsigned AW = 8,
  parameter int unsigned IW = 32,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [IW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [IW-1:0] rdata_o
);
  logic [IW-1:0] mem_q [DEPTH];

  // storage is deliberately not reset: it is loaded while the node is held in reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sxn_seq.sv
module sxn_seq import sxn_pkg::*; #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fjump_i,
  input  logic          cmp_en_i,
  input  addr_t         target_i,
  input  logic [DW-1:0] cmp_data_i,
  input  logic          cmp_vld_i,
  output addr_t         pc_o
);
  addr_t pc_q, pc_d;
  logic  cmp_zero, take;

  // an untagged compare word never counts as zero
  assign cmp_zero = cmp_vld_i && (cmp_data_i == '0);
  assign take     = fjump_i || (cmp_en_i && !cmp_zero);
  assign pc_d     = take ? target_i : pc_q + addr_t'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sxn_xbar.sv
module sxn_xbar import sxn_pkg::*; #(
  parameter int unsigned DW = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [SXN_NSRC-1:0][DW-1:0]   src_data_i,
  input  logic [SXN_NSRC-1:0]           src_vld_i,
  input  sel_t [SXN_NOUT-1:0]           sel_i,
  output logic [SXN_NREG-1:0][DW-1:0]   dst_data_o,
  output logic [SXN_NREG-1:0]           dst_vld_o,
  output logic [DW-1:0]                 cmp_data_o,
  output logic                          cmp_vld_o
);
  logic [SXN_NOUT-1:0][DW-1:0] mux_data;
  logic [SXN_NOUT-1:0]         mux_vld;
  logic [SXN_NREG-1:0][DW-1:0] q_data;
  logic [SXN_NREG-1:0]         q_vld;

  // codes at or above SXN_NSRC match no source and leave a dead word
  always_comb begin
    mux_data = '0;
    mux_vld  = '0;
    for (int k = 0; k < SXN_NOUT; k++) begin
      for (int j = 0; j < SXN_NSRC; j++) begin
        if (sel_i[k] == sel_t'(j)) begin
          mux_data[k] = src_data_i[j];
          mux_vld[k]  = src_vld_i[j];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_data <= '0;
      q_vld  <= '0;
    end else begin
      q_data <= mux_data[SXN_NREG-1:0];
      q_vld  <= mux_vld[SXN_NREG-1:0];
    end
  end

  assign dst_data_o = q_data;
  assign dst_vld_o  = q_vld;
  // comparator tap is unregistered so the branch resolves in the same cycle
  assign cmp_data_o = mux_data[SXN_CMP];
  assign cmp_vld_o  = mux_vld[SXN_CMP];
endmodule

// File: rtl/sxn_node.sv
module sxn_node import sxn_pkg::*; #(
  parameter int unsigned DW = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic [SXN_AW-1:0]             cfg_addr_i,
  input  logic [SXN_IW-1:0]             cfg_data_i,
  input  logic [SXN_NNBR-1:0][DW-1:0]   nbr_data_i,
  input  logic [SXN_NNBR-1:0]           nbr_vld_i,
  input  logic [DW-1:0]                 core_data_i,
  input  logic                          core_vld_i,
  output logic [SXN_NNBR-1:0][DW-1:0]   nbr_data_o,
  output logic [SXN_NNBR-1:0]           nbr_vld_o,
  output logic [DW-1:0]                 core_data_o,
  output logic                          core_vld_o,
  output logic [SXN_AW-1:0]             pc_o
);
  addr_t                        pc;
  logic [SXN_IW-1:0]            imem_rdata;
  instr_t                       instr;
  logic [SXN_NSRC-1:0][DW-1:0]  src_data;
  logic [SXN_NSRC-1:0]          src_vld;
  logic [SXN_NREG-1:0][DW-1:0]  dst_data;
  logic [SXN_NREG-1:0]          dst_vld;
  logic [DW-1:0]                cmp_data;
  logic                         cmp_vld;
  logic                         unused_spare;

  sxn_imem #(.AW(SXN_AW), .IW(SXN_IW)) u_imem (
    .clk_i   (clk_i),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_addr_i),
    .wdata_i (cfg_data_i),
    .raddr_i (pc),
    .rdata_o (imem_rdata)
  );

  assign instr        = instr_t'(imem_rdata);
  assign unused_spare = ^instr.spare;

  assign src_data = {core_data_i, nbr_data_i};
  assign src_vld  = {core_vld_i, nbr_vld_i};

  sxn_xbar #(.DW(DW)) u_xbar (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_data_i (src_data),
    .src_vld_i  (src_vld),
    .sel_i      (instr.sel),
    .dst_data_o (dst_data),
    .dst_vld_o  (dst_vld),
    .cmp_data_o (cmp_data),
    .cmp_vld_o  (cmp_vld)
  );

  sxn_seq #(.DW(DW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fjump_i    (instr.fjump),
    .cmp_en_i   (instr.cmp_en),
    .target_i   (instr.target),
    .cmp_data_i (cmp_data),
    .cmp_vld_i  (cmp_vld),
    .pc_o       (pc)
  );

  assign nbr_data_o  = dst_data[SXN_NNBR-1:0];
  assign nbr_vld_o   = dst_vld[SXN_NNBR-1:0];
  assign core_data_o = dst_data[SXN_CORE];
  assign core_vld_o  = dst_vld[SXN_CORE];
  assign pc_o        = pc;
endmodule

// File: rtl/sxn_node_chk.sv
module sxn_node_chk import sxn_pkg::*; #(
  parameter int unsigned DW = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input instr_t                       instr_i,
  input logic [DW-1:0]                cmp_data_i,
  input logic                         cmp_vld_i,
  input logic [SXN_AW-1:0]            pc_i,
  input logic [SXN_NNBR-1:0][DW-1:0]  nbr_data_i,
  input logic [SXN_NNBR-1:0]          nbr_vld_i,
  input logic [DW-1:0]                core_data_i,
  input logic                         core_vld_i
);
  logic [SXN_NREG-1:0][DW-1:0] out_data;
  logic [SXN_NREG-1:0]         out_vld;
  assign out_data = {core_data_i, nbr_data_i};
  assign out_vld  = {core_vld_i, nbr_vld_i};

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (pc_i == '0 && out_vld == '0 && out_data == '0)
        else $error("reset state not idle");
    end
  end

  a_r6_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!instr_i.fjump && !instr_i.cmp_en) |=> pc_i == SXN_AW'($past(pc_i) + 1'b1));

  a_r7_force_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i.fjump |=> pc_i == $past(instr_i.target));

  a_r8_cmp_zero_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i.cmp_en && !instr_i.fjump && cmp_vld_i && cmp_data_i == '0)
      |=> pc_i == SXN_AW'($past(pc_i) + 1'b1));

  a_r8_cmp_nonzero_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i.cmp_en && !instr_i.fjump && cmp_vld_i && cmp_data_i != '0)
      |=> pc_i == $past(instr_i.target));

  a_r9_cmp_untagged_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i.cmp_en && !instr_i.fjump && !cmp_vld_i) |=> pc_i == $past(instr_i.target));

  for (genvar k = 0; k < SXN_NREG; k++) begin : g_dead
    a_r4_dead_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (instr_i.sel[k] >= sel_t'(SXN_NSRC)) |=> (!out_vld[k] && out_data[k] == '0));
  end
endmodule

bind sxn_node sxn_node_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_i     (instr),
  .cmp_data_i  (cmp_data),
  .cmp_vld_i   (cmp_vld),
  .pc_i        (pc_o),
  .nbr_data_i  (nbr_data_o),
  .nbr_vld_i   (nbr_vld_o),
  .core_data_i (core_data_o),
  .core_vld_i  (core_vld_o)
);

// File: tb/sxn_node_bench.sv
module sxn_node_bench;
  localparam int unsigned DW     = 16;
  localparam time         PERIOD = 10ns;
  localparam int unsigned WD_CYC = 20000;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 cfg_we_i = 1'b0;
  logic [7:0]           cfg_addr_i = '0;
  logic [31:0]          cfg_data_i = '0;
  logic [3:0][DW-1:0]   nbr_data_i = '0;
  logic [3:0]           nbr_vld_i = '0;
  logic [DW-1:0]        core_data_i = '0;
  logic                 core_vld_i = 1'b0;
  logic [3:0][DW-1:0]   nbr_data_o;
  logic [3:0]           nbr_vld_o;
  logic [DW-1:0]        core_data_o;
  logic                 core_vld_o;
  logic [7:0]           pc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk_i = ~clk_i;

  sxn_node #(.DW(DW)) u_sxn_node (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_data_i,
    .nbr_data_i, .nbr_vld_i, .core_data_i, .core_vld_i,
    .nbr_data_o, .nbr_vld_o, .core_data_o, .core_vld_o, .pc_o
  );

  // encoding per R2
  function automatic logic [31:0] mk(input logic [2:0] s0, s1, s2, s3, s4, s5,
                                     input logic [7:0] tgt, input logic ce, fj);
    return {4'h0, fj, ce, tgt, s5, s4, s3, s2, s1, s0};
  endfunction

  localparam logic [2:0] XN = 3'd0, XE = 3'd1, XS = 3'd2, XW = 3'd3, XC = 3'd4, XD = 3'd7;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected order: north, east, south, west, core
  task automatic chk_out(input string req, input logic [4:0][DW-1:0] ed, input logic [4:0] ev);
    chk({req, " data"}, 32'({core_data_o, nbr_data_o}[DW*4 +: DW]), 32'(ed[4]));
    for (int k = 0; k < 4; k++) chk({req, " nbr data"}, 32'(nbr_data_o[k]), 32'(ed[k]));
    chk({req, " tags"}, 32'({core_vld_o, nbr_vld_o}), 32'(ev));
  endtask

  task automatic load(input logic [7:0] a, input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_data_i = d;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
  endtask

  task automatic hold_reset();
    rst_ni = 1'b0; #1;
  endtask

  task automatic release_reset();
    rst_ni = 1'b1;
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic drive(input logic [3:0][DW-1:0] nd, input logic [3:0] nv,
                       input logic [DW-1:0] cd, input logic cv);
    nbr_data_i = nd; nbr_vld_i = nv; core_data_i = cd; core_vld_i = cv;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 256; a++) load(8'(a), mk(XD, XD, XD, XD, XD, XD, 8'd0, 1'b0, 1'b0));
    chk("R1 pc in reset", 32'(pc_o), 32'd0);
    chk_out("R1 outputs in reset", '0, 5'b0);
  endtask

  task automatic t_route();
    hold_reset();
    load(8'd0, mk(XE, XS, XW, XN, XC, XD, 8'd0, 1'b0, 1'b0));
    load(8'd1, mk(3'd5, 3'd6, 3'd7, 3'd5, 3'd6, 3'd7, 8'd0, 1'b0, 1'b0));
    load(8'd2, mk(XN, XN, XN, XN, XN, XD, 8'd0, 1'b0, 1'b0));
    load(8'd3, mk(XC, XC, XC, XC, XC, XD, 8'd0, 1'b0, 1'b0));
    release_reset();
    drive({16'h4444, 16'h3333, 16'h2222, 16'h1111}, 4'hF, 16'h5555, 1'b1);
    step();
    chk_out("R3 rotate", {16'h5555, 16'h1111, 16'h4444, 16'h3333, 16'h2222}, 5'h1F);
    chk("R6 pc step", 32'(pc_o), 32'd1);
    step();
    chk_out("R4 dead codes", '0, 5'b0);
    drive({16'h4444, 16'h3333, 16'h2222, 16'hABCD}, 4'hE, 16'h5555, 1'b1);
    step();
    chk_out("R5 untagged carried", {5{16'hABCD}}, 5'b0);
    drive('0, 4'h0, 16'h0F0F, 1'b1);
    step();
    chk_out("R3 broadcast core", {5{16'h0F0F}}, 5'h1F);
    chk("R6 pc after four", 32'(pc_o), 32'd4);
    hold_reset();
    chk_out("R1 async clear", '0, 5'b0);
    chk("R1 pc async clear", 32'(pc_o), 32'd0);
  endtask

  task automatic t_wrap();
    hold_reset();
    load(8'd0, mk(XD, XD, XD, XD, XD, XD, 8'd254, 1'b0, 1'b1));
    load(8'd254, mk(XD, XD, XD, XD, XD, XD, 8'd0, 1'b0, 1'b0));
    load(8'd255, mk(XD, XD, XD, XD, XD, XD, 8'd0, 1'b0, 1'b0));
    release_reset();
    step(); chk("R7 force jump", 32'(pc_o), 32'd254);
    step(); chk("R6 pc 255", 32'(pc_o), 32'd255);
    step(); chk("R6 wrap", 32'(pc_o), 32'd0);
  endtask

  task automatic cmp_case(input string req, input logic [31:0] w, input logic [DW-1:0] cd,
                          input logic cv, input logic [DW-1:0] wd, input logic [7:0] exp_pc);
    hold_reset();
    load(8'd0, w);
    drive({wd, 16'h0000, 16'h0000, 16'h0000}, 4'hF, cd, cv);
    release_reset();
    step();
    chk(req, 32'(pc_o), 32'(exp_pc));
  endtask

  task automatic t_cmp();
    cmp_case("R8 valid zero advances", mk(XD, XD, XD, XD, XD, XC, 8'd9, 1'b1, 1'b0), 16'h0, 1'b1, 16'h7, 8'd1);
    cmp_case("R8 nonzero branches", mk(XD, XD, XD, XD, XD, XC, 8'd9, 1'b1, 1'b0), 16'h7, 1'b1, 16'h0, 8'd9);
    cmp_case("R9 untagged zero branches", mk(XD, XD, XD, XD, XD, XC, 8'd9, 1'b1, 1'b0), 16'h0, 1'b0, 16'h0, 8'd9);
    cmp_case("R7 jump beats zero", mk(XD, XD, XD, XD, XD, XC, 8'd9, 1'b1, 1'b1), 16'h0, 1'b1, 16'h0, 8'd9);
    cmp_case("R8 compare reads west", mk(XD, XD, XD, XD, XD, XW, 8'd9, 1'b1, 1'b0), 16'h3, 1'b1, 16'h0, 8'd1);
  endtask

  task automatic t_loop();
    hold_reset();
    load(8'd0, mk(XD, XC, XD, XD, XD, XD, 8'd0, 1'b0, 1'b0));
    load(8'd1, mk(XD, XD, XD, XD, XD, XC, 8'd0, 1'b1, 1'b0));
    load(8'd2, mk(XD, XD, XD, XD, XD, XD, 8'd0, 1'b0, 1'b0));
    release_reset();
    for (int i = 0; i < 3; i++) begin
      drive('0, 4'h0, 16'(16'hD0 + i), 1'b1);
      step();
      chk_out("R3 loop transfer", {16'h0, 16'h0, 16'h0, 16'(16'hD0 + i), 16'h0}, 5'b00010);
      chk("R6 loop body", 32'(pc_o), 32'd1);
      drive('0, 4'h0, 16'(2 - i), 1'b1);
      step();
      chk("R8 loop count", 32'(pc_o), (i == 2) ? 32'd2 : 32'd0);
    end
  endtask

  initial begin
    hold_reset();
    t_reset();
    t_route();
    t_wrap();
    t_cmp();
    t_loop();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule